// File: doc/BRIEF.md
# Hashed Control-Flow Automaton Monitor

This block watches the instruction stream of one packet-processing core and checks it against a precomputed deterministic automaton that describes the core's legal control flow. For every executed instruction the core reports its 32-bit word and its address. The monitor folds the two into a 4-bit hash. It then checks whether that hash is an allowed outgoing edge of the current automaton state. On a legal edge the monitor moves to the successor state. On an illegal edge it raises a one-cycle reset/recovery pulse and returns to a programmable start state.

Each state entry holds a 16-bit vector of legal hash values and the base pointer of that state's successor group. The successors are stored back to back, ordered by hash value. The next state is therefore the group base plus the number of legal hashes below the one that matched. This needs one state-memory read per instruction, so the monitor keeps pace with the core at one instruction per cycle. Software fills the state memory through a write port while the monitor is disabled. It then enables the monitor and pulses a packet-start input at the beginning of each packet.

Top module: `cfmon_top`

## Requirements
- R1: During reset and in the first cycle after it, `alarm` is 0 and `cur_state` is 0.
- R2: The edge hash is the XOR of the eight 4-bit nibbles of `instr_addr` XORed with the four nibbles `instr_word[31:28]`, `[27:24]`, `[23:20]` and `[19:16]`, which cover the opcode and the register fields.
- R3: A state entry written as `wr_data` carries the legal-hash vector in bits [15:0], where bit h set means hash h is legal, and the group base in bits [29:16]. On a legal instruction the state becomes base + k, where k is the number of set vector bits below position h. This holds up to k = 15 when all 16 bits are set.
- R4: An instruction whose hash bit is clear in the current entry makes `alarm` 1 for exactly the following cycle, and `cur_state` becomes `start_state`.
- R5: While enabled, a cycle with `instr_valid` low and `pkt_start` low leaves `cur_state` unchanged and raises no alarm.
- R6: `pkt_start` returns the state to `start_state`. An instruction in the same cycle is checked against the `start_state` entry, not the previous state.
- R7: Writes to the state memory take effect only while `enable` is low. A write attempted while enabled leaves the stored entry unchanged.
- R8: While `enable` is low, no instruction is checked, `alarm` stays 0, and `cur_state` follows `start_state` one cycle later.
- R9: A state pointer at or above the memory depth (DEPTH, default 1024) reads as an entry with no legal hashes, so any instruction there raises the alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Monitoring on; memory writes blocked while high |
| start_state | input | 14 | State entered at packet start, after an alarm and while disabled |
| pkt_start | input | 1 | Start of a new packet |
| instr_valid | input | 1 | An instruction is reported this cycle |
| instr_addr | input | 32 | Address of the reported instruction |
| instr_word | input | 32 | Reported instruction word |
| wr_en | input | 1 | State-memory write strobe |
| wr_addr | input | 14 | State index to write |
| wr_data | input | 30 | Entry: group base [29:16], legal-hash vector [15:0] |
| alarm | output | 1 | Reset/recovery pulse after an illegal edge |
| cur_state | output | 14 | Current automaton state |

## Verification
Two functions can act in the same cycle: a packet start and an instruction check. The bench first walks the automaton to a state where the coming hash would be illegal. It then asserts `pkt_start` together with an instruction whose hash is legal only in the start state. A correct design moves to the start state's successor with no alarm; a design that checks against the stale state raises an alarm instead. A second overlap is a write attempted while the monitor runs. It is judged by the behaviour of the targeted state afterwards.

// File: rtl/cfmon_pkg.sv
package cfmon_pkg;
    parameter int PTR_W   = 14;
    parameter int HASH_W  = 4;
    parameter int VEC_W   = 1 << HASH_W;
    parameter int RANK_W  = HASH_W + 1;
    parameter int ENTRY_W = PTR_W + VEC_W;

    typedef struct packed {
        logic [PTR_W-1:0] base;
        logic [VEC_W-1:0] legal;
    } entry_t;

    typedef struct packed {
        logic [PTR_W-1:0] cur;
        logic             alarm;
    } regs_t;
endpackage

// File: rtl/cfmon_hash.sv
module cfmon_hash
    import cfmon_pkg::*;
(
    input  logic [31:0]       addr,
    input  logic [31:0]       word,
    output logic [HASH_W-1:0] hash
);
    localparam int ADDR_NIB = 32 / HASH_W;
    localparam int WORD_NIB = 16 / HASH_W;

    always_comb begin
        hash = '0;
        for (int i = 0; i < ADDR_NIB; i++)
            hash = hash ^ addr[i*HASH_W +: HASH_W];
        // upper half of the word: opcode and register fields
        for (int j = 0; j < WORD_NIB; j++)
            hash = hash ^ word[16 + j*HASH_W +: HASH_W];
    end
endmodule

// File: rtl/cfmon_rank.sv
module cfmon_rank
    import cfmon_pkg::*;
(
    input  logic [VEC_W-1:0]  legal,
    input  logic [HASH_W-1:0] sel,
    output logic              hit,
    output logic [RANK_W-1:0] rank
);
    logic [VEC_W-1:0] below;

    genvar g;
    generate
        for (g = 0; g < VEC_W; g++) begin : g_mask
            assign below[g] = (HASH_W'(g) < sel);
        end
    endgenerate

    always_comb begin
        hit  = legal[sel];
        rank = '0;
        for (int i = 0; i < VEC_W; i++)
            rank = rank + RANK_W'(legal[i] & below[i]);
    end
endmodule

// File: rtl/cfmon_store.sv
module cfmon_store
    import cfmon_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic               clk,
    input  logic               wr_ok,
    input  logic [PTR_W-1:0]   wr_addr,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic [PTR_W-1:0]   rd_addr,
    output entry_t             rd_data
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam logic [PTR_W:0] LIMIT = (PTR_W+1)'(DEPTH);

    logic [ENTRY_W-1:0] mem [DEPTH];
    logic rd_in, wr_in;

    assign rd_in = {1'b0, rd_addr} < LIMIT;
    assign wr_in = {1'b0, wr_addr} < LIMIT;

    always_ff @(posedge clk) begin
        if (wr_ok && wr_in)
            mem[wr_addr[ADDR_W-1:0]] <= wr_data;
    end

    assign rd_data = rd_in ? entry_t'(mem[rd_addr[ADDR_W-1:0]]) : '0;
endmodule

// File: rtl/cfmon_top.sv
module cfmon_top
    import cfmon_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [PTR_W-1:0]   start_state,
    input  logic               pkt_start,
    input  logic               instr_valid,
    input  logic [31:0]        instr_addr,
    input  logic [31:0]        instr_word,
    input  logic               wr_en,
    input  logic [PTR_W-1:0]   wr_addr,
    input  logic [ENTRY_W-1:0] wr_data,
    output logic               alarm,
    output logic [PTR_W-1:0]   cur_state
);
    regs_t              r_q, r_d;
    logic [PTR_W-1:0]   look_state;
    entry_t             entry;
    logic [HASH_W-1:0]  hash;
    logic               hit;
    logic [RANK_W-1:0]  rank;

    assign look_state = pkt_start ? start_state : r_q.cur;

    cfmon_hash u_hash (
        .addr (instr_addr),
        .word (instr_word),
        .hash (hash)
    );

    cfmon_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_ok   (wr_en && !enable),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (look_state),
        .rd_data (entry)
    );

    cfmon_rank u_rank (
        .legal (entry.legal),
        .sel   (hash),
        .hit   (hit),
        .rank  (rank)
    );

    always_comb begin
        r_d       = r_q;
        r_d.alarm = 1'b0;
        if (!enable) begin
            r_d.cur = start_state;
        end else if (instr_valid) begin
            if (hit) begin
                r_d.cur = entry.base + PTR_W'(rank);
            end else begin
                r_d.cur   = start_state;
                r_d.alarm = 1'b1;
            end
        end else if (pkt_start) begin
            r_d.cur = start_state;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign alarm     = r_q.alarm;
    assign cur_state = r_q.cur;
endmodule

// File: rtl/cfmon_chk.sv
module cfmon_chk
    import cfmon_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic [PTR_W-1:0] start_state,
    input logic             pkt_start,
    input logic             instr_valid,
    input logic             alarm,
    input logic [PTR_W-1:0] cur_state
);
    AST_ALARM_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |-> cur_state == $past(start_state)); // R4

    AST_ALARM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |-> $past(enable && instr_valid)); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !instr_valid && !pkt_start) |=> (!alarm && $stable(cur_state))); // R5

    AST_PKT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && pkt_start && !instr_valid) |=> (!alarm && cur_state == $past(start_state))); // R6

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!alarm && cur_state == $past(start_state))); // R8
endmodule

bind cfmon_top cfmon_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .start_state (start_state),
    .pkt_start   (pkt_start),
    .instr_valid (instr_valid),
    .alarm       (alarm),
    .cur_state   (cur_state)
);

// File: tb/tb_cfmon_top.sv
module tb_cfmon_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [13:0] start_state = '0;
    logic        pkt_start = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_addr = '0;
    logic [31:0] instr_word = '0;
    logic        wr_en = 1'b0;
    logic [13:0] wr_addr = '0;
    logic [29:0] wr_data = '0;
    logic        alarm;
    logic [13:0] cur_state;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cfmon_top dut (.*);

    function automatic logic [3:0] ref_hash(input logic [31:0] a, input logic [31:0] w);
        logic [3:0] h = 4'h0;
        for (int i = 0; i < 8; i++) h ^= a[i*4 +: 4];
        h ^= w[31:28] ^ w[27:24] ^ w[23:20] ^ w[19:16];
        return h;
    endfunction

    task automatic check(input string req, input logic [13:0] exp_s, input logic exp_a);
        checks++;
        if (cur_state !== exp_s || alarm !== exp_a) begin
            fails++;
            $display("FAIL %s: state=%0d alarm=%b expected state=%0d alarm=%b",
                     req, cur_state, alarm, exp_s, exp_a);
        end
    endtask

    task automatic wr(input logic [13:0] a, input logic [13:0] base, input logic [15:0] vec);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = {base, vec};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // one cycle of stimulus; outputs sampled at the following negedge
    task automatic step(input logic v, input logic p, input logic [31:0] a, input logic [31:0] w);
        instr_valid = v; pkt_start = p; instr_addr = a; instr_word = w;
        @(negedge clk);
        instr_valid = 1'b0; pkt_start = 1'b0;
    endtask

    function automatic logic [31:0] wh(input logic [3:0] h);
        return {h, 28'h0};
    endfunction

    task automatic t_reset;
        @(negedge clk);
        check("R1 in reset", 14'd0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 14'd0, 1'b0);
    endtask

    task automatic t_program;
        wr(14'd0,   14'd10,  16'h0084);   // hashes 2 and 7
        wr(14'd10,  14'd100, 16'hFFFF);
        wr(14'd11,  14'd200, 16'h8001);
        wr(14'd115, 14'd0,   16'h0000);
        wr(14'd20,  14'd300, 16'h0001 << ref_hash(32'h1234_5678, 32'hABCD_0000));
        start_state = 14'd5;
        @(negedge clk);
        check("R8 disabled follows start", 14'd5, 1'b0);
        step(1'b1, 1'b0, 32'h0, wh(4'h3));
        check("R8 disabled ignores instr", 14'd5, 1'b0);
        start_state = 14'd0;
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_walk;
        step(1'b1, 1'b0, 32'h0, wh(4'h7));
        check("R3 rank 1", 14'd11, 1'b0);
        step(1'b0, 1'b0, 32'h0, wh(4'h3));
        check("R5 idle hold", 14'd11, 1'b0);
        step(1'b1, 1'b0, 32'h0, wh(4'hF));
        check("R3 sparse rank", 14'd201, 1'b0);
        step(1'b1, 1'b1, 32'h0, wh(4'h2));
        check("R6 pkt+instr rank 0", 14'd10, 1'b0);
        step(1'b1, 1'b0, 32'h0, wh(4'hF));
        check("R3 full vector rank 15", 14'd115, 1'b0);
        step(1'b1, 1'b0, 32'h0, wh(4'h0));
        check("R4 empty entry alarm", 14'd0, 1'b1);
        step(1'b0, 1'b0, 32'h0, 32'h0);
        check("R4 alarm one cycle", 14'd0, 1'b0);
    endtask

    task automatic t_illegal;
        step(1'b1, 1'b0, 32'h0, wh(4'h5));
        check("R4 illegal hash", 14'd0, 1'b1);
        step(1'b1, 1'b0, 32'h0, wh(4'h2));
        check("R3 after alarm rank 0", 14'd10, 1'b0);
        step(1'b0, 1'b1, 32'h0, 32'h0);
        check("R6 pkt restart", 14'd0, 1'b0);
    endtask

    task automatic t_hash;
        start_state = 14'd20;
        step(1'b0, 1'b1, 32'h0, 32'h0);
        check("R6 pkt to new start", 14'd20, 1'b0);
        step(1'b1, 1'b0, 32'h1234_5678, 32'hABCD_0000);
        check("R2 folded hash legal", 14'd300, 1'b0);
        step(1'b1, 1'b1, 32'h1234_5678, 32'hABCD_1000);
        check("R2 word bit 12 ignored", 14'd300, 1'b0);
        step(1'b1, 1'b1, 32'h1234_5679, 32'hABCD_0000);
        check("R2 address bit changes hash", 14'd20, 1'b1);
        start_state = 14'd0;
        step(1'b0, 1'b1, 32'h0, 32'h0);
    endtask

    task automatic t_write_lock;
        wr(14'd0, 14'd50, 16'h0020);      // enabled: must be dropped
        step(1'b1, 1'b1, 32'h0, wh(4'h7));
        check("R7 write while enabled dropped", 14'd11, 1'b0);
        enable = 1'b0;
        wr(14'd0, 14'd50, 16'h0020);
        enable = 1'b1;
        step(1'b1, 1'b1, 32'h0, wh(4'h5));
        check("R7 write while disabled taken", 14'd50, 1'b0);
    endtask

    task automatic t_range;
        start_state = 14'd5000;
        step(1'b0, 1'b1, 32'h0, 32'h0);
        step(1'b1, 1'b0, 32'h0, wh(4'h0));
        check("R9 out of range alarms", 14'd5000, 1'b1);
        start_state = 14'd0;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_program();
        t_walk();
        t_illegal();
        t_hash();
        t_write_lock();
        t_range();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual hung, expected completion");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule